// File: doc/BRIEF.md
# Timer Register Bridge Across Two Clock Domains

This block is an 8-bit counter with a compare register. The counter can be clocked from the bus clock or from a separate slow clock that has no phase relation to the bus. Software reaches the counter, compare and control registers through a small register bus in the bus clock domain.

While the counter runs from the slow clock, each register write is first captured in a holding register on the bus side. The write is then passed across to the timer side with a toggle handshake. A per-register busy bit in the status register stays high until the timer side has taken the value and the acknowledge has come back. Software polls that bit before the next write to the same register.

A compare hit on the timer side sets an interrupt flag in the bus domain and can toggle a waveform pin. Selecting the slow clock takes effect only while the system clock comes from an internal oscillator, which is signalled on an input pin. Otherwise the select bit falls back to 0.

Top module: `tmr_async_bridge`

## Requirements
- R1: After reset, every register reads 0, and `cmp_irq`, `wave_out` and `ext_clk_en` are 0.
- R2: The control register (address 2) has three bits: bit 0 starts the counter, bit 1 clears it on a compare hit, and bit 2 toggles the waveform on a hit. While bit 0 is 1, the counter (address 0) advances by one on every timer clock edge and wraps from 255 to 0.
- R3: A compare hit occurs on the timer clock edge at which the run bit is 1 and the counter equals the compare register (address 1). On that edge the counter becomes 0 if clear-on-hit is set, and `wave_out` toggles if toggle-on-hit is set.
- R4: The interrupt flag (address 4, bit 0) is set on the third bus clock edge after a hit edge when the timer runs from the bus clock, and `cmp_irq` follows it. Writing 1 to bit 0 clears the flag. If a set and a clear fall on the same edge, the set wins.
- R5: With the slow clock deselected, a write to address 0, 1 or 2 is visible on the next bus clock edge, and all busy bits stay 0. A counter write on an edge replaces counting on that edge, and no hit is taken on it.
- R6: Status bit 4 selects the slow clock. Writing 1 sets it only if `src_int_osc` is 1, and the bit is forced to 0 on any bus clock edge where `src_int_osc` is 0.
- R7: With status bit 4 at 1, the counter and its compare logic are clocked by `tclk`.
- R8: With status bit 4 at 1, a write to the counter, compare or control register sets busy bit 0, 1 or 2 on the next bus clock edge. The bit clears once the timer side has loaded the value and the acknowledge has returned.
- R9: A write to a register whose busy bit is 1 is ignored.
- R10: Status bit 5 drives `ext_clk_en`. It can be written only while status bit 4 is 0; a write while bit 4 is 1 leaves it unchanged.
- R11: Status bits 7, 6 and 3 read 0. Writes to the busy bits have no effect. Addresses 5 to 7 read 0.
- R12: The compare and control registers read back the last accepted write, and the counter address reads the live counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one bus clock per write |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| tclk | input | 1 | Slow asynchronous timer clock |
| src_int_osc | input | 1 | 1 when the system clock comes from an internal oscillator |
| ext_clk_en | output | 1 | External clock input enable (status bit 5) |
| cmp_irq | output | 1 | Compare interrupt flag |
| wave_out | output | 1 | Waveform output, toggled on hits |

## Verification
With the bus clock selected, a reference model follows the bench every clock and is tested with three patterns:
- A short compare period with clear-on-hit repeats the hit often, which shows whether the clear and the three-edge flag delay are right.
- Free-running near 255 with clear-on-hit off shows whether the counter wraps and hits only at equality.
- A counter write during counting shows whether the load wins over the increment.

With the slow clock selected, fixed scenarios are run:
- A second write right after a first separates an ignored write from a late-landing one.
- Polling the busy bits until they clear shows that the handshake completes.
- A hit arriving only from `tclk` shows the clock switch.

Writes to the select bit with the oscillator input low, and dropping that input, separate a granted switch from a refused one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int BUS_W = 8;
    localparam int ADR_W = 3;
    localparam int NCH   = 3;

    // transfer channel indices, also the busy bit positions in status
    localparam int CH_CNT = 0;
    localparam int CH_CMP = 1;
    localparam int CH_CTL = 2;

    localparam int ST_ASYNC = 4;
    localparam int ST_XCLK  = 5;

    typedef enum logic [ADR_W-1:0] {
        REG_CNT  = 3'd0,
        REG_CMP  = 3'd1,
        REG_CTL  = 3'd2,
        REG_STAT = 3'd3,
        REG_IFLG = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic wave_en;
        logic clr_on_hit;
        logic run;
    } ctl_t;

    function automatic logic [BUS_W-1:0] pack_status(
        input logic xclk, input logic async_m, input logic [NCH-1:0] busy);
        logic [BUS_W-1:0] s;
        s = '0;
        s[NCH-1:0]   = busy;
        s[ST_ASYNC]  = async_m;
        s[ST_XCLK]   = xclk;
        return s;
    endfunction

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/tmr_xfer_chan.sv
module tmr_xfer_chan #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         bus_clk,
    input  logic         bus_rst,
    input  logic         tim_clk,
    input  logic         tim_rst,
    input  logic         async_mode,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic         accept,
    output logic [W-1:0] hold,
    output logic         busy,
    output logic         tim_ld
);
    logic req;
    logic ack_b;
    logic req_t;
    logic req_t_d;

    assign busy   = req ^ ack_b;
    assign accept = wr && !(async_mode && busy);

    // bus side: holding register and request toggle
    always_ff @(posedge bus_clk) begin
        if (bus_rst) begin
            hold <= '0;
            req  <= 1'b0;
        end else if (accept) begin
            hold <= wdata;
            if (async_mode) req <= ~req;
        end
    end

    tmr_sync #(.W(1), .STAGES(STAGES)) u_req_sync (
        .clk(tim_clk), .rst(tim_rst), .d(req), .q(req_t)
    );

    // timer side: edge of the synchronized request is the load strobe;
    // the delayed copy doubles as the acknowledge toggle
    always_ff @(posedge tim_clk) begin
        if (tim_rst) req_t_d <= 1'b0;
        else         req_t_d <= req_t;
    end

    assign tim_ld = req_t ^ req_t_d;

    tmr_sync #(.W(1), .STAGES(STAGES)) u_ack_sync (
        .clk(bus_clk), .rst(bus_rst), .d(req_t_d), .q(ack_b)
    );
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_cnt,
    input  logic             ld_cmp,
    input  logic             ld_ctl,
    input  logic [CNT_W-1:0] d_cnt,
    input  logic [CNT_W-1:0] d_cmp,
    input  ctl_t             d_ctl,
    output logic [CNT_W-1:0] cnt,
    output logic             wave,
    output logic             hit_tgl
);
    logic [CNT_W-1:0] cmp;
    ctl_t             ctl;
    logic             hit;

    // a counter load on this edge takes precedence and suppresses the hit
    assign hit = ctl.run && !ld_cnt && (cnt == cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            cmp     <= '0;
            ctl     <= '0;
            wave    <= 1'b0;
            hit_tgl <= 1'b0;
        end else begin
            if (ld_cnt)
                cnt <= d_cnt;
            else if (ctl.run)
                cnt <= (hit && ctl.clr_on_hit) ? '0 : cnt + CNT_W'(1);
            if (ld_cmp) cmp <= d_cmp;
            if (ld_ctl) ctl <= d_ctl;
            if (hit) begin
                hit_tgl <= ~hit_tgl;
                if (ctl.wave_en) wave <= ~wave;
            end
        end
    end
endmodule

// File: rtl/tmr_async_bridge.sv
module tmr_async_bridge
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ADR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    input  logic             bus_wr,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             tclk,
    input  logic             src_int_osc,
    output logic             ext_clk_en,
    output logic             cmp_irq,
    output logic             wave_out
);
    localparam logic [ADR_W-1:0] CH_ADDR [NCH] = '{REG_CNT, REG_CMP, REG_CTL};

    logic                        async_q;
    logic                        xclk_q;
    logic                        irq_flag;
    logic                        irq_s;
    logic                        irq_d;
    logic                        irq_set;
    logic                        core_clk;
    logic [NCH-1:0]              ch_busy;
    logic [NCH-1:0]              ch_acc;
    logic [NCH-1:0]              ch_tld;
    logic [NCH-1:0]              core_ld;
    logic [NCH-1:0][BUS_W-1:0]   ch_hold;
    logic [NCH-1:0][BUS_W-1:0]   core_d;
    logic [CNT_W-1:0]            core_cnt;
    logic                        hit_tgl;
    logic                        stat_wr;
    logic                        iflg_wr;

    // timer clock selection; contents may be disturbed across a switch
    assign core_clk = async_q ? tclk : clk;

    assign stat_wr = bus_wr && (bus_addr == REG_STAT);
    assign iflg_wr = bus_wr && (bus_addr == REG_IFLG);

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        tmr_xfer_chan #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_chan (
            .bus_clk   (clk),
            .bus_rst   (rst),
            .tim_clk   (tclk),
            .tim_rst   (rst),
            .async_mode(async_q),
            .wr        (bus_wr && (bus_addr == CH_ADDR[g])),
            .wdata     (bus_wdata),
            .accept    (ch_acc[g]),
            .hold      (ch_hold[g]),
            .busy      (ch_busy[g]),
            .tim_ld    (ch_tld[g])
        );
        assign core_ld[g] = async_q ? ch_tld[g] : ch_acc[g];
        assign core_d[g]  = async_q ? ch_hold[g] : bus_wdata;
    end

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk    (core_clk),
        .rst    (rst),
        .ld_cnt (core_ld[CH_CNT]),
        .ld_cmp (core_ld[CH_CMP]),
        .ld_ctl (core_ld[CH_CTL]),
        .d_cnt  (core_d[CH_CNT][CNT_W-1:0]),
        .d_cmp  (core_d[CH_CMP][CNT_W-1:0]),
        .d_ctl  (ctl_t'(core_d[CH_CTL][2:0])),
        .cnt    (core_cnt),
        .wave   (wave_out),
        .hit_tgl(hit_tgl)
    );

    // mode and clock-enable bits
    always_ff @(posedge clk) begin
        if (rst) begin
            async_q <= 1'b0;
            xclk_q  <= 1'b0;
        end else begin
            if (!src_int_osc)
                async_q <= 1'b0;
            else if (stat_wr)
                async_q <= bus_wdata[ST_ASYNC];
            if (stat_wr && !async_q)
                xclk_q <= bus_wdata[ST_XCLK];
        end
    end

    // hit toggle brought into the bus domain
    tmr_sync #(.W(1), .STAGES(SYNC_STAGES)) u_irq_sync (
        .clk(clk), .rst(rst), .d(hit_tgl), .q(irq_s)
    );

    assign irq_set = irq_s ^ irq_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_d    <= 1'b0;
            irq_flag <= 1'b0;
        end else begin
            irq_d <= irq_s;
            if (irq_set)
                irq_flag <= 1'b1;
            else if (iflg_wr && bus_wdata[0])
                irq_flag <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_CNT:  bus_rdata[CNT_W-1:0] = core_cnt;
            REG_CMP:  bus_rdata = ch_hold[CH_CMP];
            REG_CTL:  bus_rdata = ch_hold[CH_CTL];
            REG_STAT: bus_rdata = pack_status(xclk_q, async_q, ch_busy);
            REG_IFLG: bus_rdata[0] = irq_flag;
            default:  bus_rdata = '0;
        endcase
    end

    assign ext_clk_en = xclk_q;
    assign cmp_irq    = irq_flag;
endmodule

// File: rtl/tmr_async_chk.sv
module tmr_async_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [2:0]   bus_addr,
    input logic [7:0]   bus_wdata,
    input logic         bus_wr,
    input logic [7:0]   bus_rdata,
    input logic         src_int_osc,
    input logic         async_q,
    input logic         ext_clk_en,
    input logic         cmp_busy,
    input logic [7:0]   cmp_hold,
    input logic         irq_flag,
    input logic         irq_set,
    input logic [W-1:0] core_cnt
);
    // R11
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 3'd3) |-> (bus_rdata[7:6] == 2'b00 && bus_rdata[3] == 1'b0));

    // R6
    grant_refused_chk: assert property (@(posedge clk) disable iff (rst)
        !src_int_osc |=> !async_q);

    // R8
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd1 && async_q && !cmp_busy) |=> cmp_busy);

    // R9
    busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd1 && async_q && cmp_busy) |=> $stable(cmp_hold));

    // R4
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd4 && bus_wdata[0] && !irq_set) |=> !irq_flag);

    // R4
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        irq_set |=> irq_flag);

    // R10
    xclk_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd3 && async_q) |=> $stable(ext_clk_en));

    // R5
    sync_load_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd0 && !async_q) |=> (core_cnt == $past(bus_wdata[W-1:0])));
endmodule

bind tmr_async_bridge tmr_async_chk #(.W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_wr     (bus_wr),
    .bus_rdata  (bus_rdata),
    .src_int_osc(src_int_osc),
    .async_q    (async_q),
    .ext_clk_en (ext_clk_en),
    .cmp_busy   (ch_busy[1]),
    .cmp_hold   (ch_hold[1]),
    .irq_flag   (irq_flag),
    .irq_set    (irq_set),
    .core_cnt   (core_cnt)
);

// File: tb/test_tmr_async_bridge.sv
module test_tmr_async_bridge;
    localparam int CLK_PERIOD  = 10;
    localparam int TCLK_PERIOD = 46;

    logic       clk = 1'b0;
    logic       tclk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_rdata;
    logic       src_int_osc = 1'b0;
    logic       ext_clk_en;
    logic       cmp_irq;
    logic       wave_out;

    int n_checks = 0;
    int n_err = 0;
    bit finished = 0;
    bit model_on = 1;

    // reference model state
    int m_cnt, m_cmp, m_ctl, m_async, m_xclk, m_flag, m_wave;
    bit m_pipe[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always #(TCLK_PERIOD/2) tclk = ~tclk;

    tmr_async_bridge i_tmr_async_bridge (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rdata(bus_rdata), .tclk(tclk),
        .src_int_osc(src_int_osc), .ext_clk_en(ext_clk_en),
        .cmp_irq(cmp_irq), .wave_out(wave_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic int m_read(input int a);
        case (a)
            0: return m_cnt;
            1: return m_cmp;
            2: return m_ctl;
            3: return (m_xclk << 5) | (m_async << 4);
            4: return m_flag;
            default: return 0;
        endcase
    endfunction

    // behavioural model, bus clock selected
    always @(posedge clk) begin
        bit hit, set_now, ldc, run, clr, wen;
        int old_async;
        if (rst) begin
            m_cnt = 0; m_cmp = 0; m_ctl = 0; m_async = 0;
            m_xclk = 0; m_flag = 0; m_wave = 0;
            m_pipe = '{0, 0, 0};
        end else if (model_on) begin
            ldc = bus_wr && bus_addr == 3'd0;
            run = m_ctl[0]; clr = m_ctl[1]; wen = m_ctl[2];
            hit = run && !ldc && (m_cnt == m_cmp);
            set_now = m_pipe.pop_front();
            m_pipe.push_back(hit);
            if (ldc) m_cnt = bus_wdata;
            else if (run) m_cnt = (hit && clr) ? 0 : (m_cnt + 1) % 256;
            if (hit && wen) m_wave = 1 - m_wave;
            if (bus_wr && bus_addr == 3'd1) m_cmp = bus_wdata;
            if (bus_wr && bus_addr == 3'd2) m_ctl = bus_wdata;
            old_async = m_async;
            if (!src_int_osc) m_async = 0;
            else if (bus_wr && bus_addr == 3'd3) m_async = bus_wdata[4];
            if (bus_wr && bus_addr == 3'd3 && old_async == 0) m_xclk = bus_wdata[5];
            if (set_now) m_flag = 1;
            else if (bus_wr && bus_addr == 3'd4 && bus_wdata[0]) m_flag = 0;
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        string tag;
        #3;
        if (!rst && model_on && !finished) begin
            case (bus_addr)
                3'd0: tag = "R2 counter";
                3'd1, 3'd2: tag = "R12 readback";
                3'd3: tag = "R11 status";
                3'd4: tag = "R4 flag";
                default: tag = "R11 unused";
            endcase
            check(tag, bus_rdata, m_read(bus_addr));
            check("R4 cmp_irq", cmp_irq, m_flag);
            check("R3 wave_out", wave_out, m_wave);
            check("R10 ext_clk_en", ext_clk_en, m_xclk);
        end
    end

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle(input int bitpos, input string tag);
        logic [7:0] s;
        int n;
        n = 0;
        do begin
            bus_read(3'd3, s);
            n++;
        end while (s[bitpos] && n < 400);
        check(tag, s[bitpos], 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        int n;
        repeat (20) @(negedge clk);
        rst = 1'b0;

        // R1 reset state, R11 unused addresses
        for (int a = 0; a < 8; a++) begin
            bus_read(a[2:0], r);
            check(a > 4 ? "R11 unused addr" : "R1 reset value", r, 0);
        end
        check("R1 cmp_irq reset", cmp_irq, 0);
        check("R1 wave_out reset", wave_out, 0);
        check("R1 ext_clk_en reset", ext_clk_en, 0);

        // R6 refused switch
        bus_write(3'd3, 8'h10);
        bus_read(3'd3, r);
        check("R6 select refused", r, 8'h00);

        // R10 / R11 clock enable writable, busy bits not writable
        bus_write(3'd3, 8'h2F);
        bus_read(3'd3, r);
        check("R11 status write", r, 8'h20);
        check("R10 ext_clk_en set", ext_clk_en, 1);

        // R3 short period with clear-on-hit and toggling
        bus_write(3'd1, 8'h04);
        bus_write(3'd0, 8'h00);
        bus_write(3'd2, 8'h07);
        bus_read(3'd2, r);
        check("R12 control readback", r, 8'h07);
        bus_addr = 3'd0;
        repeat (30) @(negedge clk);
        bus_write(3'd4, 8'h01);
        bus_addr = 3'd4;
        repeat (8) @(negedge clk);

        // R2 free running through wrap
        bus_write(3'd2, 8'h05);
        bus_write(3'd1, 8'hFE);
        bus_write(3'd0, 8'hFA);
        bus_addr = 3'd0;
        repeat (20) @(negedge clk);

        // R5 load beats counting
        bus_write(3'd0, 8'h10);
        #1 check("R5 direct load", bus_rdata, 8'h10);
        bus_write(3'd2, 8'h00);
        repeat (6) @(negedge clk);
        bus_write(3'd4, 8'h01);
        repeat (4) @(negedge clk);
        bus_read(3'd4, r);
        check("R4 flag cleared", r, 0);

        // slow clock section, model off
        model_on = 0;
        n = m_wave;
        src_int_osc = 1'b1;
        bus_write(3'd3, 8'h30);
        bus_read(3'd3, r);
        check("R6 select granted", r, 8'h30);
        bus_write(3'd3, 8'h10);
        bus_read(3'd3, r);
        check("R10 enable locked", r, 8'h30);
        check("R10 ext_clk_en held", ext_clk_en, 1);

        bus_write(3'd1, 8'h05);
        #1 check("R8 compare busy", bus_rdata, 8'h05);
        bus_read(3'd3, r);
        check("R8 status busy", r, 8'h32);
        bus_write(3'd1, 8'h09);
        wait_idle(1, "R8 compare busy clears");
        bus_read(3'd1, r);
        check("R9 write while busy", r, 8'h05);

        bus_write(3'd0, 8'h03);
        wait_idle(0, "R8 counter busy clears");
        bus_read(3'd0, r);
        check("R12 counter after transfer", r, 8'h03);

        bus_write(3'd2, 8'h05);
        wait_idle(2, "R8 control busy clears");
        n = 0;
        while (!cmp_irq && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check("R7 hit from tclk", cmp_irq, 1);
        check("R7 wave toggled", wave_out, 1 - m_wave);

        bus_write(3'd2, 8'h00);
        wait_idle(2, "R8 stop transfer");
        repeat (4) @(negedge clk);
        bus_write(3'd4, 8'h01);
        bus_read(3'd4, r);
        check("R4 clear in slow mode", r, 0);

        src_int_osc = 1'b0;
        repeat (2) @(negedge clk);
        bus_read(3'd3, r);
        check("R6 forced back", r, 8'h20);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule